// File: doc/BRIEF.md
# Serial volume-control write master

This block performs a single register write to an external stereo volume and tone controller over a three-wire bit-serial link. The three wires are a data line, a shift clock and a framing line that tells the receiver which byte is passing. A host hands over an address byte and a value byte on a valid/ready command port. The block then plays out the whole framing sequence without further help and raises a one-cycle done pulse when the link is back at rest.

Every hold time comes from the system clock. One parameter gives the number of system clock cycles in a microsecond, and the long (10 us) and short (1 us) holds are derived from it. A second parameter gives the number of cycles in each half-period of the shift clock. The address byte always goes out with its bit 6 set, because the receiver uses that bit to recognise it. Both bytes are shifted least significant bit first.

Top module: `volctl_serial_writer`

## Requirements
- R1: Directly after reset, and whenever no write is in progress, the framing, shift clock and data lines are all high, `cmd_ready` is high and `done` is low.
- R2: In the cycle a command is accepted and for the next 10*CLK_PER_US cycles, all three lines stay high.
- R3: The framing line then falls and stays low for HALF_CYC cycles with the shift clock high before the first clock fall. It remains low through the whole address byte.
- R4: The transmitted address byte is the command address with bit 6 forced to one. Every other bit is unchanged.
- R5: Each byte is 8 bits, least significant bit first. Each bit is a low clock phase of HALF_CYC cycles followed by a high phase of HALF_CYC cycles. The data line carries the bit for both phases, so it is stable at the clock rising edge on which the receiver samples.
- R6: Between the two bytes, all three lines are high for HALF_CYC cycles. The framing line stays high through the whole value byte.
- R7: After the last value bit, all lines stay high for 10*CLK_PER_US cycles. The framing line is then low for CLK_PER_US cycles with clock and data high. After that, all three lines return high.
- R8: `done` is high for exactly one cycle: the first cycle in which all lines are back high after R7. `cmd_ready` is low from the cycle after acceptance through the cycle before `done`, and is high in the `done` cycle.
- R9: A command presented while busy is held off and accepted in the `done` cycle, not dropped. Address and value inputs that change after acceptance have no effect on the write in progress.
- R10: A synchronous active-low reset, applied mid-write, drives all three lines high, `cmd_ready` high and `done` low in the cycle after the reset edge. The next command then starts a fresh write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command this cycle |
| cmd_addr | input | BYTE_W | Register address for the device |
| cmd_value | input | BYTE_W | Value to write |
| done | output | 1 | One-cycle pulse when the write has finished |
| link_frame | output | 1 | Framing line (low marks the address byte and the final latch) |
| link_sck | output | 1 | Shift clock, receiver samples on its rising edge |
| link_dat | output | 1 | Serial data line |

## Verification
The assertions assume that reset is held low for at least one clock edge before any command, so that the line registers start from their rest value. They also assume that `cmd_valid` is only taken as accepted when `cmd_ready` is high. The bench drives reset from time zero and raises it only after several edges. It changes the command inputs only between clock edges and decides acceptance from the same `cmd_ready` level the design sees. It deliberately changes the address and value while a write is in flight and keeps `cmd_valid` asserted across a busy period, so the hold-off and capture rules are exercised rather than assumed.

// File: rtl/volctl_pkg.sv
// Package volctl_pkg
// Shared types for the serial volume-control write master: the sequencer
// state encoding, the bundle of three link lines, and the decode from a
// sequencer state to line levels. Assumes the link rests with all lines high.
package volctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_IDSET = 3'd2,
        ST_ABIT  = 3'd3,
        ST_GAP   = 3'd4,
        ST_VBIT  = 3'd5,
        ST_TAIL1 = 3'd6,
        ST_TAIL2 = 3'd7
    } vc_state_e;

    typedef struct packed {
        logic frame;
        logic sck;
        logic dat;
    } link_pins_t;

    localparam link_pins_t LINK_REST = 3'b111;

    // Map a sequencer state, clock phase and current bit to line levels.
    function automatic link_pins_t pins_for(vc_state_e st, logic hi, logic b);
        link_pins_t p;
        p = LINK_REST;
        case (st)
            ST_IDSET, ST_TAIL2: p.frame = 1'b0;
            ST_ABIT: begin
                p.frame = 1'b0;
                p.sck   = hi;
                p.dat   = b;
            end
            ST_VBIT: begin
                p.sck = hi;
                p.dat = b;
            end
            default: p = LINK_REST;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/volctl_hold_timer.sv
// Module volctl_hold_timer
// Loadable down-counter used for every timed phase. Loading D-1 makes the
// phase last D cycles: expired is high while the count is zero.
// Assumes load values fit in TW bits. Stops at zero.
module volctl_hold_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt_q;

    // Count register: load wins, otherwise step down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R2 / R7: hold windows shrink by exactly one per cycle.
    p_countdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R2: a load is taken as given.
    p_load_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/volctl_bit_shifter.sv
// Module volctl_bit_shifter
// Holds the byte being sent and presents its bits least significant first.
// advance moves to the next bit. last_bit flags the final bit of the byte.
// Assumes the sequencer never advances past the final bit.
module volctl_bit_shifter #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              advance,
    output logic              cur_bit,
    output logic              last_bit
);

    localparam int unsigned CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

    logic [BYTE_W-1:0] sr_q;
    logic [CW-1:0]     idx_q;

    // Shift register and bit index: load restarts, advance shifts right.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '1;
            idx_q <= '0;
        end else if (load) begin
            sr_q  <= load_byte;
            idx_q <= '0;
        end else if (advance) begin
            sr_q  <= {1'b1, sr_q[BYTE_W-1:1]};
            idx_q <= idx_q + 1'b1;
        end
    end

    assign cur_bit  = sr_q[0];
    assign last_bit = (idx_q == CW'(BYTE_W - 1));

    // R5: never more than BYTE_W bits per byte.
    p_no_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> !last_bit);

    // R5: the next bit presented is the next higher bit of the byte.
    p_lsb_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> (cur_bit == $past(sr_q[1])));

endmodule

// File: rtl/volctl_frame_seq.sv
// Module volctl_frame_seq
// Sequencer for one framed write. It captures the command, marks the address,
// steps through the lead hold, the framing setup, the address byte, the gap
// between bytes, the value byte and the two tail holds. It drives the timer
// and the shifter, and decodes the next line levels. Assumes the timer
// reports expiry in the cycle its count is zero.
module volctl_frame_seq
    import volctl_pkg::*;
#(
    parameter int unsigned BYTE_W   = 8,
    parameter int unsigned MARK_BIT = 6,
    parameter int unsigned TW       = 8,
    parameter logic [TW-1:0] LONG_M1  = '0,
    parameter logic [TW-1:0] SHORT_M1 = '0,
    parameter logic [TW-1:0] HALF_M1  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [BYTE_W-1:0] cmd_addr,
    input  logic [BYTE_W-1:0] cmd_value,
    output logic              cmd_ready,
    output logic              done,
    input  logic              tmr_exp,
    output logic              tmr_load,
    output logic [TW-1:0]     tmr_val,
    output logic              sh_load,
    output logic [BYTE_W-1:0] sh_byte,
    output logic              sh_adv,
    input  logic              sh_last,
    input  logic              sh_bit,
    output link_pins_t        pins_next
);

    localparam logic [BYTE_W-1:0] ADDR_MARK = BYTE_W'(1) << MARK_BIT;

    vc_state_e         state_q, state_d;
    logic              hi_q, hi_d;
    logic              t2end_q;
    logic              done_q;
    logic [BYTE_W-1:0] addr_q;
    logic [BYTE_W-1:0] val_q;
    logic              fire;
    logic              finish;

    assign cmd_ready = (state_q == ST_IDLE) && !t2end_q;
    assign fire      = cmd_valid && cmd_ready;
    assign done      = done_q;
    assign sh_byte   = (state_q == ST_GAP) ? val_q : addr_q;
    assign pins_next = pins_for(state_q, hi_q, sh_bit);

    // Next-state logic: advance one phase each time the running hold expires.
    always_comb begin
        state_d  = state_q;
        hi_d     = hi_q;
        tmr_load = 1'b0;
        tmr_val  = HALF_M1;
        sh_load  = 1'b0;
        sh_adv   = 1'b0;
        finish   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (fire) begin
                    state_d  = ST_LEAD;
                    tmr_load = 1'b1;
                    tmr_val  = LONG_M1;
                end
            end
            ST_LEAD: begin
                if (tmr_exp) begin
                    state_d  = ST_IDSET;
                    tmr_load = 1'b1;
                end
            end
            ST_IDSET: begin
                if (tmr_exp) begin
                    state_d  = ST_ABIT;
                    hi_d     = 1'b0;
                    tmr_load = 1'b1;
                    sh_load  = 1'b1;
                end
            end
            ST_ABIT, ST_VBIT: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    if (!hi_q) begin
                        hi_d = 1'b1;
                    end else if (sh_last) begin
                        hi_d = 1'b0;
                        if (state_q == ST_ABIT) begin
                            state_d = ST_GAP;
                        end else begin
                            state_d = ST_TAIL1;
                            tmr_val = LONG_M1;
                        end
                    end else begin
                        hi_d   = 1'b0;
                        sh_adv = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_exp) begin
                    state_d  = ST_VBIT;
                    hi_d     = 1'b0;
                    tmr_load = 1'b1;
                    sh_load  = 1'b1;
                end
            end
            ST_TAIL1: begin
                if (tmr_exp) begin
                    state_d  = ST_TAIL2;
                    tmr_load = 1'b1;
                    tmr_val  = SHORT_M1;
                end
            end
            ST_TAIL2: begin
                if (tmr_exp) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, clock phase and completion pipeline registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hi_q    <= 1'b1;
            t2end_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            hi_q    <= hi_d;
            t2end_q <= finish;
            done_q  <= t2end_q;
        end
    end

    // Command capture: the address is marked on the way in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            val_q  <= '0;
        end else if (fire) begin
            addr_q <= cmd_addr | ADDR_MARK;
            val_q  <= cmd_value;
        end
    end

    // R8: an accepted command makes the block busy on the next cycle.
    p_fire_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !cmd_ready);

    // R2: acceptance always starts the lead hold.
    p_fire_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (state_q == ST_LEAD));

endmodule

// File: rtl/volctl_serial_writer.sv
// Module volctl_serial_writer
// Top of the serial volume-control write master. It ties the sequencer, the
// hold timer and the bit shifter together and registers the three link lines
// so that they leave the block glitch-free. Assumes CLK_PER_US >= 1 and
// HALF_CYC >= 1.
module volctl_serial_writer
    import volctl_pkg::*;
#(
    parameter int unsigned CLK_PER_US = 50,
    parameter int unsigned HALF_CYC   = 2,
    parameter int unsigned BYTE_W     = 8,
    parameter int unsigned MARK_BIT   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [BYTE_W-1:0] cmd_addr,
    input  logic [BYTE_W-1:0] cmd_value,
    output logic              done,
    output logic              link_frame,
    output logic              link_sck,
    output logic              link_dat
);

    localparam int unsigned HOLD_LONG  = 10 * CLK_PER_US;
    localparam int unsigned HOLD_SHORT = CLK_PER_US;
    localparam int unsigned HOLD_MAX   = (HOLD_LONG > HALF_CYC) ? HOLD_LONG : HALF_CYC;
    localparam int unsigned TW         = $clog2(HOLD_MAX + 1);
    localparam logic [TW-1:0] LONG_M1  = TW'(HOLD_LONG - 1);
    localparam logic [TW-1:0] SHORT_M1 = TW'(HOLD_SHORT - 1);
    localparam logic [TW-1:0] HALF_M1  = TW'(HALF_CYC - 1);

    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_exp;
    logic              sh_load;
    logic [BYTE_W-1:0] sh_byte;
    logic              sh_adv;
    logic              sh_last;
    logic              sh_bit;
    link_pins_t        pins_next;
    link_pins_t        pins_q;

    volctl_frame_seq #(
        .BYTE_W   (BYTE_W),
        .MARK_BIT (MARK_BIT),
        .TW       (TW),
        .LONG_M1  (LONG_M1),
        .SHORT_M1 (SHORT_M1),
        .HALF_M1  (HALF_M1)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_addr  (cmd_addr),
        .cmd_value (cmd_value),
        .cmd_ready (cmd_ready),
        .done      (done),
        .tmr_exp   (tmr_exp),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .sh_load   (sh_load),
        .sh_byte   (sh_byte),
        .sh_adv    (sh_adv),
        .sh_last   (sh_last),
        .sh_bit    (sh_bit),
        .pins_next (pins_next)
    );

    volctl_hold_timer #(
        .TW (TW)
    ) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    volctl_bit_shifter #(
        .BYTE_W (BYTE_W)
    ) sh_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_byte (sh_byte),
        .advance   (sh_adv),
        .cur_bit   (sh_bit),
        .last_bit  (sh_last)
    );

    // Output register: lines rest high in reset, else follow the decode.
    always_ff @(posedge clk) begin
        if (!rst_n) pins_q <= LINK_REST;
        else        pins_q <= pins_next;
    end

    assign link_frame = pins_q.frame;
    assign link_sck   = pins_q.sck;
    assign link_dat   = pins_q.dat;

    // R10: reset puts the link at rest on the following cycle.
    p_reset_rest_r10: assert property (@(posedge clk)
        !rst_n |=> (link_frame && link_sck && link_dat && !done));

    // R1: whenever a command can be taken, the link is at rest.
    p_ready_rest_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (link_frame && link_sck && link_dat));

    // R8: done is a single-cycle pulse, seen with the link at rest and ready high.
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_rest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cmd_ready && link_frame && link_sck && link_dat));

    // R5: data does not move while the shift clock stays low.
    p_dat_stable_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_sck && $past(!link_sck)) |-> $stable(link_dat));

    // R6: the framing line only rises while the shift clock is high.
    p_frame_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_frame) |-> link_sck);

endmodule

// File: tb/volctl_serial_writer_tb.sv
// Bench volctl_serial_writer_tb_top
// Behavioural reference: every accepted command expands into a queue of
// expected per-cycle line levels, which is compared with the design once
// per clock. A receiver model captures bits on shift-clock rising edges.
module volctl_serial_writer_tb_top;

    localparam int CPU   = 5;
    localparam int HB    = 2;
    localparam int LONG  = 10 * CPU;
    localparam int SHORT = CPU;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_addr = 8'h00;
    logic [7:0] cmd_value = 8'h00;
    wire        cmd_ready;
    wire        done;
    wire        link_frame;
    wire        link_sck;
    wire        link_dat;

    always #10ns clk = ~clk;

    volctl_serial_writer #(
        .CLK_PER_US (CPU),
        .HALF_CYC   (HB),
        .BYTE_W     (8),
        .MARK_BIT   (6)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_addr   (cmd_addr),
        .cmd_value  (cmd_value),
        .done       (done),
        .link_frame (link_frame),
        .link_sck   (link_sck),
        .link_dat   (link_dat)
    );

    typedef struct {
        bit    f;
        bit    c;
        bit    d;
        bit    r;
        bit    dn;
        string tag;
    } exp_t;

    exp_t       q[$];
    int         checks = 0;
    int         fails = 0;
    bit         prev_sck = 1'b1;
    bit         seen_done = 1'b0;
    logic [7:0] rx_a = 8'h00;
    logic [7:0] rx_v = 8'h00;
    int         na = 0;
    int         nv = 0;

    function automatic void push_n(int n, bit f, bit c, bit d, bit r, bit dn, string t);
        exp_t e;
        e.f = f; e.c = c; e.d = d; e.r = r; e.dn = dn; e.tag = t;
        for (int k = 0; k < n; k++) q.push_back(e);
    endfunction

    // Expected waveform of one write, from the accept cycle to the done cycle.
    function automatic void build(logic [7:0] a, logic [7:0] v);
        logic [7:0] am;
        am = a | 8'h40;                              // R4: bit 6 marked
        push_n(1, 1, 1, 1, 0, 0, "R8");              // accept cycle, ready drops
        push_n(LONG, 1, 1, 1, 0, 0, "R2");           // lead hold
        push_n(HB, 0, 1, 1, 0, 0, "R3");             // framing setup
        for (int i = 0; i < 8; i++) begin            // R4/R5 address, LSB first
            push_n(HB, 0, 0, am[i], 0, 0, "R4");
            push_n(HB, 0, 1, am[i], 0, 0, "R4");
        end
        push_n(HB, 1, 1, 1, 0, 0, "R6");             // gap between bytes
        for (int i = 0; i < 8; i++) begin            // R5 value, LSB first
            push_n(HB, 1, 0, v[i], 0, 0, "R5");
            push_n(HB, 1, 1, v[i], 0, 0, "R5");
        end
        push_n(LONG, 1, 1, 1, 0, 0, "R7");           // tail hold
        push_n(SHORT, 0, 1, 1, 0, 0, "R7");          // latch pulse
        push_n(1, 1, 1, 1, 1, 1, "R8");              // done cycle
    endfunction

    task automatic check(bit ok, string tag, int got, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, expv);
        end
    endtask

    // One clock: register acceptance, advance, then compare away from the edge.
    task automatic tick();
        exp_t e;
        if (!rst_n) q.delete();
        else if (cmd_valid && cmd_ready) begin
            build(cmd_addr, cmd_value);
            rx_a = 8'h00; rx_v = 8'h00; na = 0; nv = 0;
        end
        @(posedge clk);
        @(negedge clk);
        if (q.size() > 0) e = q.pop_front();
        else begin
            e.f = 1; e.c = 1; e.d = 1; e.r = 1; e.dn = 0; e.tag = "R1";
        end
        checks++;
        if ({link_frame, link_sck, link_dat, cmd_ready, done} !== {e.f, e.c, e.d, e.r, e.dn}) begin
            fails++;
            $display("FAIL %s: frame/sck/dat/ready/done got %b%b%b%b%b expected %b%b%b%b%b",
                     e.tag, link_frame, link_sck, link_dat, cmd_ready, done,
                     e.f, e.c, e.d, e.r, e.dn);
        end
        if (link_sck && !prev_sck) begin
            if (!link_frame) begin rx_a = {link_dat, rx_a[7:1]}; na++; end
            else             begin rx_v = {link_dat, rx_v[7:1]}; nv++; end
        end
        prev_sck  = link_sck;
        seen_done = done;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 2000; k++) begin
            tick();
            if (seen_done) break;
        end
    endtask

    task automatic rx_check(logic [7:0] a, logic [7:0] v);
        check(rx_a == (a | 8'h40), "R4 received address", rx_a, a | 8'h40);
        check(rx_v == v, "R5 received value", rx_v, v);
        check(na == 8 && nv == 8, "R5 bits per byte", na * 16 + nv, 8 * 16 + 8);
    endtask

    task automatic accept(logic [7:0] a, logic [7:0] v);
        bit acc;
        cmd_valid = 1'b1; cmd_addr = a; cmd_value = v;
        for (int k = 0; k < 2000; k++) begin
            acc = cmd_ready;
            tick();
            if (acc) break;
        end
    endtask

    task automatic send(logic [7:0] a, logic [7:0] v);
        accept(a, v);
        cmd_valid = 1'b0; cmd_addr = ~a; cmd_value = ~v;   // R9: late changes ignored
        wait_done();
        rx_check(a, v);
    endtask

    initial begin
        // R1 / R10: reset state
        repeat (3) tick();
        rst_n = 1'b1;
        repeat (3) tick();

        // R2..R8: plain writes with varied patterns
        send(8'h05, 8'hA3);
        send(8'h00, 8'hFF);
        send(8'h7F, 8'h01);
        repeat (4) tick();

        // R9: second command held while busy, accepted in the done cycle
        accept(8'h12, 8'h34);
        cmd_addr = 8'h21; cmd_value = 8'h5A;
        wait_done();
        rx_check(8'h12, 8'h34);
        check(cmd_ready == 1'b1, "R9 ready in done cycle", cmd_ready, 1);
        tick();
        cmd_valid = 1'b0; cmd_addr = 8'h00; cmd_value = 8'h00;
        wait_done();
        rx_check(8'h21, 8'h5A);

        // R10: reset in the middle of the address byte
        accept(8'h33, 8'h44);
        cmd_valid = 1'b0;
        repeat (LONG + 8) tick();
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        repeat (3) tick();
        send(8'h0A, 8'hC5);
        repeat (5) tick();

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #2ms;
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule